// File: doc/BRIEF.md
# Floating-Point Operand Classify, Sort and Unpack Unit

This unit speeds up software emulation of wide floating-point arithmetic. It does in one operation what emulation code would otherwise spend a run of integer instructions on. Two binary64 values enter together. Each is placed in one of five classes. The pair comes back with the larger magnitude in the first slot. Each value also comes back split into sign, unbiased exponent and a full significand with the hidden bit made explicit.

The unit also returns a swap flag and the class codes of both slots. Emulation code can then build a special-case answer (for NaN, infinity or zero) alongside the ordinary integer path, and use the classes to pick between the two at the end. Packing and rounding are left to other code. The operand widths are parameters; the defaults give binary64.

Top module: `fp_pair_sorter`

## Requirements
- R1: Each operand is classed from its exponent field E and fraction field F. E=0 with F=0 gives Zero (3'b000). E=0 with F nonzero gives Subnormal (3'b001). E all ones with F=0 gives Infinity (3'b011). E all ones with F nonzero gives NaN (3'b100). Any other E gives Normal (3'b010).
- R2: The class code, sign, exponent and significand of the operand placed in the first slot appear together on the big_* ports. Those of the other operand appear together on the small_* ports.
- R3: When neither operand is NaN, the two are compared on all bits except the sign (bits 62..0), read as an unsigned integer. The larger one goes to the big_* ports, and swap is 1 exactly when op_b was the larger.
- R4: A NaN always goes to the big_* ports ahead of a non-NaN. When both operands are NaN, op_a stays first and swap is 0.
- R5: When the two magnitudes are equal (for example +0 and -0), op_a stays first and swap is 0.
- R6: The significand output is 53 bits wide. Bit 52 is 1 when E is nonzero and 0 when E is zero. Bits 51..0 equal F.
- R7: The exponent output is a 12-bit two's complement value. It equals E-1023 when E is nonzero, which gives +1024 for Infinity and NaN. It equals -1022 when E is zero.
- R8: Each sign output is bit 63 of the operand routed to that slot.
- R9: All results are registered and appear one clock after a cycle with in_vld high. out_vld is high in exactly the cycle after each cycle with in_vld high.
- R10: In a cycle with in_vld low, the inputs are ignored and every data output keeps its previous value.
- R11: While rst_n is low, out_vld and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair valid |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| out_vld | output | 1 | Result valid |
| swap | output | 1 | 1 when op_b was placed first |
| big_cls | output | 3 | Class of the first-slot operand |
| big_sign | output | 1 | Sign of the first-slot operand |
| big_exp | output | 12 | Unbiased exponent of the first-slot operand |
| big_sig | output | 53 | Significand of the first-slot operand |
| small_cls | output | 3 | Class of the second-slot operand |
| small_sign | output | 1 | Sign of the second-slot operand |
| small_exp | output | 12 | Unbiased exponent of the second-slot operand |
| small_sig | output | 53 | Significand of the second-slot operand |

## Verification
Several properties are checked on every cycle:
- For non-NaN pairs, the first slot is never smaller than the second in (exponent, significand) order.
- A NaN never sits in the second slot behind a non-NaN.
- A swap only happens when the first slot is strictly larger.
- Significands agree with their classes.
- The valid output trails the valid input by one cycle.
- Outputs hold when no valid input arrives.

Only the bench scenarios can show the rest: that each class code and exponent matches the raw bit pattern, that ties and NaN pairs keep the input order, and that the sign and fields follow the right operand. The bench checks these by comparing against values it computes itself, over random and directed operand pairs.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

  // Class codes carried on the *_cls outputs
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fp_cls_e;

  localparam int CLS_W = 3;

endpackage

// File: rtl/fpcs_unpack.sv
module fpcs_unpack
  import fpcs_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] val,
  output fp_cls_e               cls,
  output logic                  sign,
  output logic [EXP_W:0]        uexp,
  output logic [FRAC_W:0]       sig
);

  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int UEXP_W = EXP_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [UEXP_W-1:0] BIAS_V = UEXP_W'(BIAS);
  localparam logic [UEXP_W-1:0] SUB_EXP = UEXP_W'(1) - BIAS_V;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;
  logic              exp_ones;
  logic              frac_zero;

  always_comb begin
    exp_f     = val[W-2:FRAC_W];
    frac_f    = val[FRAC_W-1:0];
    exp_zero  = (exp_f == '0);
    exp_ones  = &exp_f;
    frac_zero = (frac_f == '0);
  end

  // class decode
  always_comb begin
    if (exp_zero)      cls = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_ones) cls = frac_zero ? CLS_INF  : CLS_NAN;
    else               cls = CLS_NORM;
  end

  // field unpack
  always_comb begin
    sign = val[W-1];
    uexp = exp_zero ? SUB_EXP : ({1'b0, exp_f} - BIAS_V);
    sig  = {~exp_zero, frac_f};
  end

  // R6: significand leading bit agrees with the class
  p_hidden_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_NORM || cls == CLS_INF || cls == CLS_NAN) |-> sig[FRAC_W]);
  p_hidden_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_ZERO) |-> (sig == '0));
  // R7: small-exponent operands share the minimum unbiased exponent
  p_sub_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_SUB || cls == CLS_ZERO) |-> (uexp == SUB_EXP));

endmodule

// File: rtl/fpcs_order.sv
module fpcs_order
  import fpcs_pkg::*;
#(
  parameter int MAG_W = 63,
  parameter int BW    = 70
) (
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             a_nan,
  input  logic             b_nan,
  input  logic [BW-1:0]    a_bnd,
  input  logic [BW-1:0]    b_bnd,
  output logic             swap,
  output logic [BW-1:0]    big_bnd,
  output logic [BW-1:0]    small_bnd
);

  logic b_gt;

  always_comb begin
    b_gt = (b_mag > a_mag);
    // a NaN in slot A never moves; a NaN in slot B overtakes a non-NaN
    if (a_nan)      swap = 1'b0;
    else if (b_nan) swap = 1'b1;
    else            swap = b_gt;
  end

  always_comb begin
    big_bnd   = swap ? b_bnd : a_bnd;
    small_bnd = swap ? a_bnd : b_bnd;
  end

endmodule

// File: rtl/fpcs_stage.sv
module fpcs_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic          q_vld,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_nxt;
  logic          vld_nxt;

  always_comb begin
    q_nxt   = en ? d : q;
    vld_nxt = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q     <= q_nxt;
      q_vld <= vld_nxt;
    end
  end

endmodule

// File: rtl/fp_pair_sorter.sv
module fp_pair_sorter
  import fpcs_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic                  out_vld,
  output logic                  swap,
  output logic [2:0]            big_cls,
  output logic                  big_sign,
  output logic [EXP_W:0]        big_exp,
  output logic [FRAC_W:0]       big_sig,
  output logic [2:0]            small_cls,
  output logic                  small_sign,
  output logic [EXP_W:0]        small_exp,
  output logic [FRAC_W:0]       small_sig
);

  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = W - 1;
  localparam int UEXP_W = EXP_W + 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BW     = CLS_W + 1 + UEXP_W + SIG_W;
  localparam int DW     = 1 + 2 * BW;

  logic [W-1:0]      ops   [2];
  fp_cls_e           u_cls [2];
  logic              u_sgn [2];
  logic [UEXP_W-1:0] u_exp [2];
  logic [SIG_W-1:0]  u_sig [2];
  logic [BW-1:0]     bnd   [2];

  always_comb begin
    ops[0] = op_a;
    ops[1] = op_b;
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_side
    fpcs_unpack #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) i_unpack (
      .clk (clk),
      .rst_n(rst_n),
      .val (ops[gi]),
      .cls (u_cls[gi]),
      .sign(u_sgn[gi]),
      .uexp(u_exp[gi]),
      .sig (u_sig[gi])
    );
    always_comb bnd[gi] = {u_cls[gi], u_sgn[gi], u_exp[gi], u_sig[gi]};
  end

  logic          c_swap;
  logic [BW-1:0] c_big;
  logic [BW-1:0] c_small;

  fpcs_order #(
    .MAG_W(MAG_W),
    .BW   (BW)
  ) i_order (
    .a_mag    (op_a[MAG_W-1:0]),
    .b_mag    (op_b[MAG_W-1:0]),
    .a_nan    (u_cls[0] == CLS_NAN),
    .b_nan    (u_cls[1] == CLS_NAN),
    .a_bnd    (bnd[0]),
    .b_bnd    (bnd[1]),
    .swap     (c_swap),
    .big_bnd  (c_big),
    .small_bnd(c_small)
  );

  logic [DW-1:0] r_q;

  fpcs_stage #(
    .DW(DW)
  ) i_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_vld),
    .d    ({c_swap, c_big, c_small}),
    .q_vld(out_vld),
    .q    (r_q)
  );

  always_comb begin
    {swap, big_cls, big_sign, big_exp, big_sig,
     small_cls, small_sign, small_exp, small_sig} = r_q;
  end

  // ordering key usable for any non-NaN value
  logic signed [UEXP_W-1:0] k_big_e;
  logic signed [UEXP_W-1:0] k_small_e;
  logic                     big_ge;
  logic                     big_gt;

  always_comb begin
    k_big_e   = $signed(big_exp);
    k_small_e = $signed(small_exp);
    big_gt = (k_big_e > k_small_e) ||
             ((k_big_e == k_small_e) && (big_sig > small_sig));
    big_ge = big_gt || ((k_big_e == k_small_e) && (big_sig == small_sig));
  end

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && big_cls != CLS_NAN && small_cls != CLS_NAN) |-> big_ge);
  p_nan_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && small_cls == CLS_NAN) |-> (big_cls == CLS_NAN));
  p_nan_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && swap) |-> (small_cls != CLS_NAN));
  p_tie_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && swap && big_cls != CLS_NAN) |-> big_gt);
  p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(big_sig) && $stable(small_sig) &&
                 $stable(big_exp) && $stable(small_exp) && $stable(swap)));

endmodule

// File: tb/test_fp_pair_sorter.sv
module test_fp_pair_sorter;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [63:0] op_a;
  logic [63:0] op_b;
  logic        out_vld;
  logic        swap;
  logic [2:0]  big_cls;
  logic        big_sign;
  logic [11:0] big_exp;
  logic [52:0] big_sig;
  logic [2:0]  small_cls;
  logic        small_sign;
  logic [11:0] small_exp;
  logic [52:0] small_sig;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  fp_pair_sorter i_fp_pair_sorter (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(out_vld), .swap(swap),
    .big_cls(big_cls), .big_sign(big_sign), .big_exp(big_exp), .big_sig(big_sig),
    .small_cls(small_cls), .small_sign(small_sign), .small_exp(small_exp),
    .small_sig(small_sig)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [2:0] f_cls(logic [63:0] x);
    if (x[62:52] == 11'd0)      return (x[51:0] == 0) ? 3'd0 : 3'd1;
    if (x[62:52] == 11'h7ff)    return (x[51:0] == 0) ? 3'd3 : 3'd4;
    return 3'd2;
  endfunction

  function automatic logic [11:0] f_exp(logic [63:0] x);
    if (x[62:52] == 11'd0) return 12'hc02;
    return {1'b0, x[62:52]} - 12'd1023;
  endfunction

  function automatic logic [52:0] f_sig(logic [63:0] x);
    return {(x[62:52] != 11'd0), x[51:0]};
  endfunction

  function automatic logic f_swap(logic [63:0] a, logic [63:0] b);
    if (f_cls(a) == 3'd4) return 1'b0;
    if (f_cls(b) == 3'd4) return 1'b1;
    return (b[62:0] > a[62:0]);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one valid pair, check one clock later, then one idle cycle check
  task automatic run_pair(logic [63:0] a, logic [63:0] b, string tag);
    logic        s;
    logic [63:0] hi;
    logic [63:0] lo;
    s  = f_swap(a, b);
    hi = s ? b : a;
    lo = s ? a : b;
    @(negedge clk);
    in_vld = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_vld = 1'b0; op_a = ~a; op_b = ~b;
    chk({"R9 out_vld ", tag}, 64'(out_vld), 64'd1);
    chk({"R3/R4/R5 swap ", tag}, 64'(swap), 64'(s));
    chk({"R1/R2 big_cls ", tag}, 64'(big_cls), 64'(f_cls(hi)));
    chk({"R1/R2 small_cls ", tag}, 64'(small_cls), 64'(f_cls(lo)));
    chk({"R8 big_sign ", tag}, 64'(big_sign), 64'(hi[63]));
    chk({"R8 small_sign ", tag}, 64'(small_sign), 64'(lo[63]));
    chk({"R7 big_exp ", tag}, 64'(big_exp), 64'(f_exp(hi)));
    chk({"R7 small_exp ", tag}, 64'(small_exp), 64'(f_exp(lo)));
    chk({"R6 big_sig ", tag}, 64'(big_sig), 64'(f_sig(hi)));
    chk({"R6 small_sig ", tag}, 64'(small_sig), 64'(f_sig(lo)));
    @(negedge clk);
    // R10: inputs changed while in_vld low, outputs must hold
    chk({"R9 idle out_vld ", tag}, 64'(out_vld), 64'd0);
    chk({"R10 hold big_sig ", tag}, 64'(big_sig), 64'(f_sig(hi)));
    chk({"R10 hold small_exp ", tag}, 64'(small_exp), 64'(f_exp(lo)));
    chk({"R10 hold swap ", tag}, 64'(swap), 64'(s));
  endtask

  function automatic logic [63:0] rnd_op();
    logic [10:0] e;
    logic [51:0] f;
    int unsigned k;
    k = $urandom % 8;
    f = {$urandom, $urandom};
    case (k)
      0: begin e = 11'd0; f = '0; end
      1: begin e = 11'd0; f[0] = 1'b1; end
      2: begin e = 11'h7ff; f = '0; end
      3: begin e = 11'h7ff; f[0] = 1'b1; end
      default: e = 11'(1 + ($urandom % 2046));
    endcase
    return {1'($urandom), e, f};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    logic [63:0] b;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_vld = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_vld", 64'(out_vld), 64'd0);
    chk("R11 swap", 64'(swap), 64'd0);
    chk("R11 big_sig", 64'(big_sig), 64'd0);
    chk("R11 small_exp", 64'(small_exp), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_pair(64'h0000000000000000, 64'h8000000000000000, "R5 +0/-0 tie");
    run_pair(64'h3ff0000000000000, 64'hbff0000000000000, "R5 +1/-1 tie");
    run_pair(64'h0000000000000001, 64'h0010000000000000, "R3 sub vs min normal");
    run_pair(64'h7ff0000000000000, 64'h7ff0000000000001, "R4 inf vs nan");
    run_pair(64'h7ff8000000000000, 64'hfff0000000000000, "R4 nan vs inf");
    run_pair(64'h7ff0000000000001, 64'hfff8000000000000, "R4 nan pair");
    run_pair(64'h7fefffffffffffff, 64'h7ff0000000000000, "R3 max vs inf");
    run_pair(64'h000fffffffffffff, 64'h0000000000000000, "R1 max sub vs zero");
    run_pair(64'hc000000000000000, 64'h4008000000000000, "R8 signs");

    // random pairs
    for (int i = 0; i < 400; i++) begin
      a = rnd_op();
      b = (($urandom % 6) == 0) ? {~a[63], a[62:0]} : rnd_op();
      run_pair(a, b, "random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule